// File: doc/BRIEF.md
# Dual-Controller Bus Ownership Selector

This block decides which of two upstream bus controllers currently owns a shared downstream two-wire bus. Each upstream side raises a one-cycle request strobe to claim the bus. The block drives a channel-select vector to the external pass switches. That vector has at most one bit set, and it may be all zero. After reset it holds either channel 0 or no channel, as chosen by a parameter.

When ownership moves, the block latches a lost-ownership flag for the side that gave up the bus. When the downstream bus is recovered before a switch, it latches a completion flag for the side that gains it. Each upstream side has an active-low, level-type interrupt output. That output combines the two latched flags with the downstream interrupt input, and each source has its own enable or mask. The affected side clears its latched flags with a clear strobe.

When recovery is requested, the block disconnects both channels. It raises a request to a separate recovery sequencer and connects the new owner only after that sequencer reports done. Without recovery, the switch takes place at the clock edge that samples the request.

Top module: `bus_owner_sel`

## Requirements
- R1: Reset is asynchronous and active low, and it returns all state to defaults. With the default parameter `START_CH0=1`, `sel_o` is `2'b01`; with `START_CH0=0` it is `2'b00`. In both cases `int_no` is `2'b11` and `recov_req_o` is 0.
- R2: `sel_o` never has both bits set; bit 0 connects side 0 and bit 1 connects side 1.
- R3: With `recov_en_i` low, a request from a side that does not own the bus makes `sel_o` one-hot for that side at the next clock edge.
- R4: Only a side that does not currently own the bus competes. If both sides compete in the same cycle, side 0 wins.
- R5: A request from the current owner is ignored. So is any request made while a recovery switch is pending; `sel_o` and `recov_req_o` stay unchanged.
- R6: When a switch takes effect and another side owned the bus before it, a lost flag is latched for that previous owner. While that flag is unmasked, it drives the previous owner's `int_no` bit low.
- R7: With `recov_en_i` high, an accepted request sets `sel_o` to `2'b00` and `recov_req_o` to 1 at the next edge. At the edge that samples `recov_done_i` high, `sel_o` becomes one-hot for the target and `recov_req_o` returns to 0. A completion flag is latched for the target, and while unmasked it drives that side's `int_no` low.
- R8: `int_no[s]` is low whenever `dn_int_ni` is low and `fwd_en_i[s]` is high. This path is combinational and needs no clock.
- R9: A masked lost flag (`mask_lost_i[s]`) or completion flag (`mask_done_i[s]`) never pulls `int_no[s]` low. The flag stays latched, so removing the mask exposes it.
- R10: `clr_i[s]` clears both latched flags of side `s` at the next edge. A flag set in the same cycle wins over the clear.
- R11: `recov_done_i` has no effect when no recovery switch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 2 | Per-side ownership request strobe |
| clr_i | input | 2 | Per-side clear strobe for latched flags |
| fwd_en_i | input | 2 | Per-side downstream interrupt forwarding enable |
| mask_lost_i | input | 2 | Per-side mask for the lost-ownership flag |
| mask_done_i | input | 2 | Per-side mask for the recovery-completion flag |
| recov_en_i | input | 1 | Route accepted switches through bus recovery |
| recov_done_i | input | 1 | Recovery sequencer finished |
| dn_int_ni | input | 1 | Downstream interrupt, active low |
| sel_o | output | 2 | Channel select to the pass switches, one-hot or none |
| recov_req_o | output | 1 | Recovery requested, high while a switch is pending |
| int_no | output | 2 | Per-side upstream interrupt, active low |

## Verification
The bench targets the following corner cases:
- Both sides request at once while one of them already owns the bus. An arbiter that gives fixed priority without excluding the owner would keep side 0 and never hand over.
- Requests arrive while a recovery switch is pending, and a stray done arrives while idle. A design that accepts either one would reconnect a channel during recovery or switch to a stale target.
- A clear strobe lands in the same cycle as a new lost event. A design where the clear wins would drop an ownership-loss notice.
- A masked flag is later unmasked. A design that gated the flag's set instead of its output would stay silent.

// File: rtl/bos_pkg.sv
package bos_pkg;
  localparam int NSIDE = 2;
  typedef logic [NSIDE-1:0] side_vec_t;

  function automatic side_vec_t side_bit(input logic s);
    return side_vec_t'(1) << s;
  endfunction
endpackage

// File: rtl/bos_arbiter.sv
module bos_arbiter
  import bos_pkg::*;
#(
  parameter bit START_CH0 = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  side_vec_t req_i,
  input  logic      recov_en_i,
  input  logic      recov_done_i,
  output side_vec_t sel_o,
  output logic      recov_req_o,
  output side_vec_t lost_set_o,
  output side_vec_t done_set_o
);
  localparam side_vec_t SEL_RST = START_CH0 ? side_vec_t'(1) : '0;

  side_vec_t sel_q, prev_q;
  logic      pend_q, tgt_q;

  side_vec_t cand;
  logic      acc, win, go_direct, go_recov;

  // only a non-owner competes; side 0 has priority
  assign cand      = req_i & ~sel_q;
  assign acc       = ~pend_q & (|cand);
  assign win       = ~cand[0];
  assign go_direct = acc & ~recov_en_i;
  assign go_recov  = pend_q & recov_done_i;

  always_comb begin
    lost_set_o = '0;
    done_set_o = '0;
    if (go_recov) begin
      lost_set_o = prev_q & ~side_bit(tgt_q);
      done_set_o = side_bit(tgt_q);
    end else if (go_direct) begin
      lost_set_o = sel_q & ~side_bit(win);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_RST;
      prev_q <= '0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
    end else if (go_recov) begin
      sel_q  <= side_bit(tgt_q);
      pend_q <= 1'b0;
    end else if (acc) begin
      if (recov_en_i) begin
        pend_q <= 1'b1;
        tgt_q  <= win;
        prev_q <= sel_q;
        sel_q  <= '0;  // break before make during recovery
      end else begin
        sel_q  <= side_bit(win);
      end
    end
  end

  assign sel_o       = sel_q;
  assign recov_req_o = pend_q;

  p_sel_onehot0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));

  p_direct_side1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && req_i == 2'b10 && !sel_q[1] && !recov_en_i) |=> sel_q == 2'b10);

  p_both_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && req_i == 2'b11 && sel_q == 2'b00 && !recov_en_i) |=> sel_q == 2'b01);

  p_owner_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && sel_q != 2'b00 && req_i == sel_q) |=> $stable(sel_q));

  p_pend_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !recov_done_i) |=> (pend_q && $stable(tgt_q)));

  p_pend_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> sel_q == 2'b00);

  p_done_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && recov_done_i) |=> (!pend_q && $onehot(sel_q)));

  p_idle_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && recov_done_i && cand == 2'b00) |=> ($stable(sel_q) && !pend_q));
endmodule

// File: rtl/bos_irq_side.sv
module bos_irq_side (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lost_set_i,
  input  logic done_set_i,
  input  logic clr_i,
  input  logic mask_lost_i,
  input  logic mask_done_i,
  input  logic fwd_en_i,
  input  logic dn_int_ni,
  output logic int_no
);
  logic lost_q, done_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      lost_q <= lost_set_i | (lost_q & ~clr_i);
      done_q <= done_set_i | (done_q & ~clr_i);
    end
  end

  logic src_lost, src_done, src_fwd;
  assign src_lost = lost_q & ~mask_lost_i;
  assign src_done = done_q & ~mask_done_i;
  assign src_fwd  = fwd_en_i & ~dn_int_ni;
  assign int_no   = ~(src_lost | src_done | src_fwd);

  p_lost_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_set_i |=> lost_q);

  p_done_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_q);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !lost_set_i && !done_set_i) |=> (!lost_q && !done_q));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && lost_q) |=> lost_q);
endmodule

// File: rtl/bus_owner_sel.sv
module bus_owner_sel #(
  parameter bit START_CH0 = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] fwd_en_i,
  input  logic [1:0] mask_lost_i,
  input  logic [1:0] mask_done_i,
  input  logic       recov_en_i,
  input  logic       recov_done_i,
  input  logic       dn_int_ni,
  output logic [1:0] sel_o,
  output logic       recov_req_o,
  output logic [1:0] int_no
);
  import bos_pkg::*;

  side_vec_t lost_set, done_set;

  bos_arbiter #(.START_CH0(START_CH0)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .recov_en_i   (recov_en_i),
    .recov_done_i (recov_done_i),
    .sel_o        (sel_o),
    .recov_req_o  (recov_req_o),
    .lost_set_o   (lost_set),
    .done_set_o   (done_set)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    bos_irq_side u_irq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lost_set_i  (lost_set[s]),
      .done_set_i  (done_set[s]),
      .clr_i       (clr_i[s]),
      .mask_lost_i (mask_lost_i[s]),
      .mask_done_i (mask_done_i[s]),
      .fwd_en_i    (fwd_en_i[s]),
      .dn_int_ni   (dn_int_ni),
      .int_no      (int_no[s])
    );
  end

  p_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_int_ni && fwd_en_i[0]) |-> !int_no[0]);

  p_sel_vs_recov_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_req_o |-> sel_o == 2'b00);
endmodule

// File: tb/bus_owner_sel_tb.sv
module bus_owner_sel_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = '0, clr = '0, fwd = '0, ml = '0, md = '0;
  logic       ren = 1'b0, rdone = 1'b0, dn_n = 1'b1;
  logic [1:0] sel, int_n, sel0, int_n0;
  logic       rreq, rreq0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_sel #(.START_CH0(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .clr_i(clr), .fwd_en_i(fwd),
    .mask_lost_i(ml), .mask_done_i(md), .recov_en_i(ren), .recov_done_i(rdone),
    .dn_int_ni(dn_n), .sel_o(sel), .recov_req_o(rreq), .int_no(int_n));

  bus_owner_sel #(.START_CH0(1'b0)) dut0_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .clr_i(clr), .fwd_en_i(fwd),
    .mask_lost_i(ml), .mask_done_i(md), .recov_en_i(ren), .recov_done_i(rdone),
    .dn_int_ni(dn_n), .sel_o(sel0), .recov_req_o(rreq0), .int_no(int_n0));

  task automatic chk(input string tag, input string what, input logic [1:0] act,
                     input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model for dut_i (START_CH0=1)
  int m_owner = 0;
  bit m_pend = 0;
  int m_tgt = 0;
  int m_prev = -1;
  bit m_lost [2];
  bit m_done [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = 0; m_pend = 0; m_tgt = 0; m_prev = -1;
      for (int s = 0; s < 2; s++) begin m_lost[s] = 0; m_done[s] = 0; end
    end else begin
      bit sl [2];
      bit sd [2];
      int w;
      sl[0] = 0; sl[1] = 0; sd[0] = 0; sd[1] = 0;
      if (m_pend) begin
        if (rdone) begin
          if (m_prev >= 0) sl[m_prev] = 1;
          sd[m_tgt] = 1;
          m_owner = m_tgt;
          m_pend = 0;
        end
      end else begin
        w = -1;
        if (req[0] && m_owner != 0) w = 0;
        else if (req[1] && m_owner != 1) w = 1;
        if (w >= 0) begin
          if (ren) begin
            m_pend = 1; m_tgt = w; m_prev = m_owner; m_owner = -1;
          end else begin
            if (m_owner >= 0) sl[m_owner] = 1;
            m_owner = w;
          end
        end
      end
      for (int s = 0; s < 2; s++) begin
        m_lost[s] = sl[s] ? 1'b1 : (clr[s] ? 1'b0 : m_lost[s]);
        m_done[s] = sd[s] ? 1'b1 : (clr[s] ? 1'b0 : m_done[s]);
      end
    end
  end

  function automatic logic [1:0] exp_sel();
    return (m_owner < 0) ? 2'b00 : (m_owner == 0 ? 2'b01 : 2'b10);
  endfunction

  function automatic logic [1:0] exp_int();
    logic [1:0] r;
    for (int s = 0; s < 2; s++)
      r[s] = !((m_lost[s] && !ml[s]) || (m_done[s] && !md[s]) || (fwd[s] && !dn_n));
    return r;
  endfunction

  always @(negedge clk) begin
    #1;
    chk("R3,R4,R7", "model sel_o", sel, exp_sel());
    chk("R6,R8,R9,R10", "model int_no", int_n, exp_int());
    chk("R7", "model recov_req_o", {1'b0, rreq}, {1'b0, m_pend});
    chk("R2", "sel_o not both", {1'b0, sel == 2'b11}, 2'b00);
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (2) tick();
    chk("R1", "reset sel ch0", sel, 2'b01);
    chk("R1", "reset sel none", sel0, 2'b00);
    chk("R1", "reset int", int_n, 2'b11);
    chk("R1", "reset recov", {1'b0, rreq}, 2'b00);
    rst_n = 1'b1;
    tick();

    req = 2'b11; tick(); req = '0;
    chk("R4", "owner excluded", sel, 2'b10);
    chk("R6", "lost side0", int_n, 2'b10);
    chk("R4", "side0 priority", sel0, 2'b01);
    chk("R6", "no prev owner", int_n0, 2'b11);

    req = 2'b10; tick(); req = '0;
    chk("R5", "owner request", sel, 2'b10);

    clr = 2'b01; tick(); clr = '0;
    chk("R10", "clear side0", int_n, 2'b11);

    ml = 2'b10; req = 2'b01; tick(); req = '0;
    chk("R3", "switch to side0", sel, 2'b01);
    chk("R9", "lost masked", int_n, 2'b11);
    ml = 2'b00; #1;
    chk("R9", "unmask exposes", int_n, 2'b01);
    clr = 2'b10; tick(); clr = '0;

    req = 2'b10; clr = 2'b01; tick(); req = '0;
    chk("R10", "set wins clear", int_n, 2'b10);
    tick(); clr = '0;

    ren = 1'b1; req = 2'b01; tick(); req = '0;
    chk("R7", "recov blank", sel, 2'b00);
    chk("R7", "recov req", {1'b0, rreq}, 2'b01);
    req = 2'b10; tick(); req = '0;
    chk("R5", "pending ignores", sel, 2'b00);
    chk("R5", "pending stays", {1'b0, rreq}, 2'b01);
    tick();
    rdone = 1'b1; tick(); rdone = 1'b0;
    chk("R7", "commit target", sel, 2'b01);
    chk("R7", "recov drop", {1'b0, rreq}, 2'b00);
    chk("R6", "lost+done", int_n, 2'b00);
    md = 2'b01; #1;
    chk("R9", "done masked", int_n, 2'b01);
    md = 2'b00;
    clr = 2'b11; tick(); clr = '0;
    chk("R10", "clear both", int_n, 2'b11);

    ren = 1'b0; rdone = 1'b1; tick(); rdone = 1'b0;
    chk("R11", "idle done sel", sel, 2'b01);
    chk("R11", "idle done recov", {1'b0, rreq}, 2'b00);

    fwd = 2'b01; dn_n = 1'b0; #1;
    chk("R8", "fwd side0", int_n, 2'b10);
    fwd = 2'b11; #1;
    chk("R8", "fwd both", int_n, 2'b00);
    fwd = 2'b00; #1;
    chk("R8", "fwd off", int_n, 2'b11);
    dn_n = 1'b1;

    req = 2'b10; tick(); req = '0;
    rst_n = 1'b0; #1;
    chk("R1", "async reset sel", sel, 2'b01);
    chk("R1", "async reset int", int_n, 2'b11);
    tick(); rst_n = 1'b1; tick();

    for (int i = 0; i < 4000; i++) begin
      req   = 2'(($urandom % 4 == 0) ? $urandom : 0);
      clr   = 2'(($urandom % 6 == 0) ? $urandom : 0);
      rdone = ($urandom % 4 == 0);
      dn_n  = ($urandom % 8 != 0);
      if ($urandom % 16 == 0) fwd = 2'($urandom);
      if ($urandom % 16 == 0) ml  = 2'($urandom);
      if ($urandom % 16 == 0) md  = 2'($urandom);
      if ($urandom % 8 == 0)  ren = 1'($urandom);
      rst_n = ($urandom % 300 != 0);
      tick();
    end
    rst_n = 1'b1;
    tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule